// File: doc/BRIEF.md
# Two-Channel PCM Frame Transmit Serializer with Control Echo

This block assembles the outgoing 28-slot serial frame of a dual-channel voice line interface and shifts it onto an open-drain data line. A rising edge on the transmit sync input starts a frame. Each later rising edge of the bit clock moves the line to the next slot. Every channel contributes its 8-bit PCM byte, followed by four echo bits: its power state and its three latch values, as the receive side currently holds them. Both the bit clock and the sync are sampled by the block's system clock. All outputs are registered.

The line is modelled as open-drain. `tx_data_o` carries the logical slot value. `tx_oe_o` pulls the line low only for a 0. Released slots read as 1. A channel whose power bit is off sends the all-ones idle code in place of its PCM byte. While the global power input is low, the whole line is released and frames are not started.

Top module: `pcm_echo_tx`

## Requirements
- R1: After reset, and before the first frame, `tx_data_o` is 1 and `tx_oe_o` is 0.
- R2: Slot order within a frame is fixed. Slots 1 to 8 carry channel 1's byte `pcm_i[7:0]`, MSB first. Slot 9 carries `ch_on_i[0]`. Slots 10, 11 and 12 carry `latch_i[2]`, `latch_i[1]` and `latch_i[0]`. Slots 13 to 16 read as 1. Slots 17 to 28 carry the same layout for channel 2, using `pcm_i[15:8]`, `ch_on_i[1]` and `latch_i[5:3]`.
- R3: The outputs change only in the system clock cycle after a rising edge of `bclk_i` or `tsync_i` has been sampled. In every other cycle they hold their value.
- R4: A sampled rising edge of `tsync_i` puts slot 1 on the line one clock later. This holds whether or not the edge coincides with a bit clock rise. A coinciding bit clock rise does not advance the frame.
- R5: The PCM bytes, power bits and latch values are captured when the frame starts. Changes to them during the frame do not alter it.
- R6: If a channel's bit in `ch_on_i` is 0 when the frame starts, that channel's eight PCM slots read 11111111. Its echo slots still carry 0 and its latch values.
- R7: While `pwr_on_i` is low, the line is released from the next clock on (`tx_data_o` = 1, `tx_oe_o` = 0). Any frame in flight is dropped, and sync edges start no frame.
- R8: `tx_oe_o` is 1 exactly when `tx_data_o` is 0.
- R9: After slot 28, further bit clock rises leave the line released until the next sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples bit clock and sync |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| tsync_i | input | 1 | Transmit frame sync; rising edge starts a frame |
| pwr_on_i | input | 1 | Global power; low releases the line |
| ch_on_i | input | 2 | Per-channel power bit held by the receive side (bit 0 = channel 1) |
| latch_i | input | 6 | Latch values held by the receive side (bits 2:0 channel 1, 5:3 channel 2) |
| pcm_i | input | 16 | PCM bytes (bits 7:0 channel 1, 15:8 channel 2) |
| tx_data_o | output | 1 | Logical value of the current slot |
| tx_oe_o | output | 1 | Pull-down enable of the open-drain line |

## Verification
Every result lands one system clock after the edge that causes it. That edge is a sync rise for slot 1, a bit clock rise for each later slot, and a falling power input for the release. The bench changes all inputs on the falling clock edge, so each edge is sampled on the next rising edge. It reads the outputs at the falling edge that follows. It also samples once in the middle of every bit period, where no edge has occurred and the previous slot must still be present. These samples are compared with a frame image that the bench builds from the inputs it drove at the sync edge.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  parameter int unsigned NCH       = 2;
  parameter int unsigned PCM_W     = 8;
  parameter int unsigned LATCH_W   = 3;
  parameter int unsigned CH_SLOT_W = 16;
  localparam int unsigned GRP_W    = PCM_W + 1 + LATCH_W;
  localparam int unsigned FRAME_W  = (NCH - 1) * CH_SLOT_W + GRP_W;
endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  // reset high: a level already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '1;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pcm_tx_frame.sv
module pcm_tx_frame
  import pcm_tx_pkg::*;
#(
  parameter int unsigned N_CH   = NCH,
  parameter int unsigned P_W    = PCM_W,
  parameter int unsigned L_W    = LATCH_W,
  parameter int unsigned SLOT_W = CH_SLOT_W,
  localparam int unsigned G_W   = P_W + 1 + L_W,
  localparam int unsigned F_W   = (N_CH - 1) * SLOT_W + G_W
) (
  input  logic [N_CH-1:0]     ch_on_i,
  input  logic [N_CH*L_W-1:0] latch_i,
  input  logic [N_CH*P_W-1:0] pcm_i,
  output logic [F_W-1:0]      frame_o
);
  localparam int unsigned PAD_W = SLOT_W - G_W;
  logic [N_CH*SLOT_W-1:0] full;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [P_W-1:0] byte_sel;
    logic [L_W-1:0] lat;
    assign byte_sel = ch_on_i[c] ? pcm_i[c*P_W +: P_W] : '1;
    assign lat      = latch_i[c*L_W +: L_W];
    if (PAD_W > 0) begin : g_pad
      assign full[(N_CH-1-c)*SLOT_W +: SLOT_W] = {byte_sel, ch_on_i[c], lat, {PAD_W{1'b1}}};
    end else begin : g_nopad
      assign full[(N_CH-1-c)*SLOT_W +: SLOT_W] = {byte_sel, ch_on_i[c], lat};
    end
  end

  assign frame_o = full[N_CH*SLOT_W-1 -: F_W];
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int unsigned F_W = 28,
  localparam int unsigned CNT_W = $clog2(F_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [F_W-1:0] frame_i,
  output logic           msb_o,
  output logic           busy_o
);
  logic [F_W-1:0]   sr_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      left_q <= '0;
    end else if (clear_i) begin
      sr_q   <= '1;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      left_q <= CNT_W'(F_W);
    end else if (shift_i) begin
      sr_q <= {sr_q[F_W-2:0], 1'b1};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign msb_o  = sr_q[F_W-1];
  assign busy_o = (left_q != '0);
endmodule

// File: rtl/pcm_echo_tx.sv
module pcm_echo_tx
  import pcm_tx_pkg::*;
#(
  parameter int unsigned N_CH   = NCH,
  parameter int unsigned P_W    = PCM_W,
  parameter int unsigned L_W    = LATCH_W,
  parameter int unsigned SLOT_W = CH_SLOT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                tsync_i,
  input  logic                pwr_on_i,
  input  logic [N_CH-1:0]     ch_on_i,
  input  logic [N_CH*L_W-1:0] latch_i,
  input  logic [N_CH*P_W-1:0] pcm_i,
  output logic                tx_data_o,
  output logic                tx_oe_o
);
  localparam int unsigned F_W = (N_CH - 1) * SLOT_W + P_W + 1 + L_W;

  logic [1:0]     rise;
  logic [F_W-1:0] frame;
  logic           msb;
  logic           busy;
  logic           load;
  logic           shift;

  pcm_tx_edge #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({tsync_i, bclk_i}),
    .rise_o (rise)
  );

  pcm_tx_frame #(.N_CH(N_CH), .P_W(P_W), .L_W(L_W), .SLOT_W(SLOT_W)) u_frame (
    .ch_on_i (ch_on_i),
    .latch_i (latch_i),
    .pcm_i   (pcm_i),
    .frame_o (frame)
  );

  // sync wins over a coinciding bit clock rise
  assign load  = pwr_on_i & rise[1];
  assign shift = pwr_on_i & rise[0] & ~rise[1];

  pcm_tx_shift #(.F_W(F_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~pwr_on_i),
    .load_i  (load),
    .shift_i (shift),
    .frame_i (frame),
    .msb_o   (msb),
    .busy_o  (busy)
  );

  assign tx_data_o = msb;
  assign tx_oe_o   = ~msb;
endmodule

// File: rtl/pcm_echo_tx_chk.sv
module pcm_echo_tx_chk #(
  parameter int unsigned P_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bclk_i,
  input logic           tsync_i,
  input logic           pwr_on_i,
  input logic [1:0]     ch_on_i,
  input logic [2*P_W-1:0] pcm_i,
  input logic           busy,
  input logic           tx_data_o,
  input logic           tx_oe_o
);
  assert_release_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> (tx_data_o && !tx_oe_o));

  assert_idle_released_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (tx_data_o && !tx_oe_o));

  assert_first_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_i && tsync_i && !$past(tsync_i)) |=>
      (tx_data_o == ($past(ch_on_i[0]) ? $past(pcm_i[P_W-1]) : 1'b1)));

  assert_hold_between_edges_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_on_i && !(bclk_i && !$past(bclk_i)) && !(tsync_i && !$past(tsync_i)))
      |=> $stable(tx_data_o));

  assert_drive_only_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tx_oe_o, tx_data_o}) == 1);
endmodule

bind pcm_echo_tx pcm_echo_tx_chk #(.P_W(P_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bclk_i    (bclk_i),
  .tsync_i   (tsync_i),
  .pwr_on_i  (pwr_on_i),
  .ch_on_i   (ch_on_i),
  .pcm_i     (pcm_i),
  .busy      (busy),
  .tx_data_o (tx_data_o),
  .tx_oe_o   (tx_oe_o)
);

// File: tb/sim_pcm_echo_tx.sv
`timescale 1ns/1ps
module sim_pcm_echo_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0;
  logic        tsync = 1'b0;
  logic        pwr_on = 1'b1;
  logic [1:0]  ch_on = 2'b11;
  logic [5:0]  latch = '0;
  logic [15:0] pcm = '0;
  logic        tx_data;
  logic        tx_oe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pcm_echo_tx u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .bclk_i    (bclk),
    .tsync_i   (tsync),
    .pwr_on_i  (pwr_on),
    .ch_on_i   (ch_on),
    .latch_i   (latch),
    .pcm_i     (pcm),
    .tx_data_o (tx_data),
    .tx_oe_o   (tx_oe)
  );

  function automatic logic [27:0] exp_frame(logic [15:0] p, logic [5:0] l, logic [1:0] on);
    logic [7:0] b1, b2;
    b1 = on[0] ? p[7:0]  : 8'hFF;
    b2 = on[1] ? p[15:8] : 8'hFF;
    return {b1, on[0], l[2], l[1], l[0], 4'hF, b2, on[1], l[5], l[4], l[3]};
  endfunction

  function automatic logic exp_bit(int s, logic [27:0] f, bit off);
    if (off || s < 1 || s > 28) return 1'b1;
    return f[28-s];
  endfunction

  task automatic check(string tag, logic e);
    checks++;
    if (tx_data !== e || tx_oe !== ~e) begin
      errors++;
      $display("FAIL %s: data/oe = %b/%b, expected %b/%b", tag, tx_data, tx_oe, e, ~e);
    end
  endtask

  // cut_slot: 0 none, 1 power off before sync, n>1 power drops before slot n
  task automatic run_frame(bit late, int cut_slot, bit churn);
    logic [27:0] f;
    bit off;
    f = exp_frame(pcm, latch, ch_on);
    off = (cut_slot == 1);
    @(negedge clk); bclk = 1'b0; if (off) pwr_on = 1'b0;
    @(negedge clk);
    if (late) begin
      bclk = 1'b1;
      @(negedge clk); tsync = 1'b1;
    end else begin
      tsync = 1'b1; bclk = 1'b1;
    end
    @(negedge clk);
    check(off ? "R7 sync ignored" : "R4 slot 1", exp_bit(1, f, off));
    if (churn) begin
      pcm = 16'($urandom()); latch = 6'($urandom()); ch_on = 2'($urandom());
    end
    for (int s = 2; s <= 30; s++) begin
      bclk = 1'b0; tsync = 1'b0;
      if (s == cut_slot) begin pwr_on = 1'b0; off = 1'b1; end
      @(negedge clk);
      check(off ? "R7 released" : "R3 hold", exp_bit(s - 1, f, off));
      @(negedge clk); bclk = 1'b1;
      @(negedge clk);
      if (off)         check("R7 released", 1'b1);
      else if (s > 28) check("R9 after frame", 1'b1);
      else if (s <= 8 && !f[19] || s >= 17 && s <= 24 && !f[3])
                       check("R6 idle code", exp_bit(s, f, 1'b0));
      else             check(churn ? "R2 R5 slot" : "R2 slot", exp_bit(s, f, 1'b0));
    end
    @(negedge clk); pwr_on = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", 1'b1);
    pcm = 16'hC35A; latch = 6'b101_011; ch_on = 2'b11;
    run_frame(1'b0, 0, 1'b0);
    ch_on = 2'b10; pcm = 16'h0000; latch = 6'b010_110;
    run_frame(1'b0, 0, 1'b0);
    ch_on = 2'b01; pcm = 16'h1234;
    run_frame(1'b1, 0, 1'b0);
    ch_on = 2'b00; latch = 6'b111_111;
    run_frame(1'b1, 0, 1'b1);
    ch_on = 2'b11; pcm = 16'h0F0F; latch = 6'b000_000;
    run_frame(1'b0, 10, 1'b0);
    run_frame(1'b0, 1, 1'b0);
    for (int i = 0; i < 14; i++) begin
      pcm = 16'($urandom()); latch = 6'($urandom()); ch_on = 2'($urandom());
      run_frame(1'($urandom()), 0, 1'($urandom()));
    end
    // R8: the enable must be low whenever a 1 is on the line
    check("R8 idle line", 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule